// File: doc/BRIEF.md
# Command Queue Descriptor and Read Pointer

This block keeps the 64-bit descriptor of a circular command queue held in memory, together with the read offset that a command fetcher uses to walk through that queue. Software sees the descriptor as two 32-bit words that it can read and write independently. It also sees the read offset as a third, read-only word. The descriptor carries a Valid flag, a 4 KB-aligned base address, inner and outer cacheability codes, a shareability code, and the queue length in 4 KB pages minus one.

The fetch side raises a one-cycle advance pulse each time it consumes a command. The block moves the read offset forward by one command and returns the physical address of the next command, wrapping at the end of the queue. Any accepted descriptor write rewinds the queue to its start. Descriptor writes are refused while the queue engine is enabled or has not yet gone quiescent.

Top module: `cmdq_desc_reg`

## Requirements
- R1: Register word 0 holds descriptor bits [31:0] and word 1 holds bits [63:32]. A write to one word leaves the fields of the other word unchanged. Field positions are: Valid [63], inner cacheability [61:59], outer cacheability [55:53], base address [51:12], shareability [11:10], size [7:0].
- R2: After reset, words 0, 1 and 2 read zero, Valid is 0 and the fetch address is 0.
- R3: Reserved bits 62, [58:56], 52 and [9:8] always read 0, whatever value was written to them.
- R4: Base address bits [15:12] always read 0 and never contribute to the fetch address.
- R5: A shareability write of 2'b11 is stored as 2'b00. It then reads back as 2'b00 and appears as 2'b00 on the shareability output. Other values are stored and output unchanged.
- R6: Every accepted write to word 0 or word 1 sets the read offset to zero.
- R7: A write to word 0 or word 1 is ignored when the engine-enable input is 1 or the engine-quiescent input is 0.
- R8: Each cycle with the advance input high moves the read offset forward by 32 bytes, but only while Valid is 1. While Valid is 0 the offset does not move.
- R9: The read offset returns to zero when it would reach 4096 × (size + 1) bytes.
- R10: The fetch address is the base address, with bits [15:12] and bits [51:48] dropped, plus the read offset, taken as 48 bits.
- R11: Word 2 reads the read offset in bytes, with bits [4:0] always 0. Writes to word 2 have no effect. Word 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Word select: 0 low descriptor, 1 high descriptor, 2 read offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word (combinational) |
| eng_enable | input | 1 | Queue engine enabled; descriptor writes are refused while it is 1 |
| eng_quiescent | input | 1 | Queue engine idle; descriptor writes are refused while it is 0 |
| fetch_adv | input | 1 | One command consumed |
| fetch_addr | output | 48 | Physical address of the next command |
| q_valid | output | 1 | Queue memory allocated |
| q_pages | output | 8 | Queue length in 4 KB pages minus one |
| q_inner | output | 3 | Inner cacheability code |
| q_outer | output | 3 | Outer cacheability code |
| q_share | output | 2 | Shareability code after sanitising |

## Verification
The bench builds the block with its default parameters: 32-byte commands and a 48-bit fetch address. With these values the largest queue holds 32768 commands, so running one full lap at size 255 fits easily in the cycle budget. That run reaches both the last command address and the wrap back to zero. The one-page queue then gives a short wrap after 128 advances. Setting every base bit, including bits [51:48] and [15:12], shows which bits are left out of the 48-bit fetch address.

// File: rtl/cmdq_desc_reg.sv
`timescale 1ns/1ps
module cmdq_desc_reg #(
  parameter int CMD_LOG2 = 5,
  parameter int FETCH_AW = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                eng_enable,
  input  logic                eng_quiescent,
  input  logic                fetch_adv,
  output logic [FETCH_AW-1:0] fetch_addr,
  output logic                q_valid,
  output logic [7:0]          q_pages,
  output logic [2:0]          q_inner,
  output logic [2:0]          q_outer,
  output logic [1:0]          q_share
);
  localparam int PAGE_LOG2 = 12;
  localparam int SIZE_W    = 8;
  localparam int CPP_LOG2  = PAGE_LOG2 - CMD_LOG2;
  localparam int OFF_W     = SIZE_W + CPP_LOG2;

  logic        valid_q;
  logic [2:0]  inner_q, outer_q;
  logic [51:16] base_q;
  logic [1:0]  share_q;
  logic [7:0]  size_q;
  logic [OFF_W-1:0] off_q;

  logic wr_ok, wr_lo, wr_hi;
  logic [OFF_W:0] off_nxt, lim;
  logic wrap;

  assign wr_ok = reg_wr && !reg_addr[1] && !eng_enable && eng_quiescent;
  assign wr_lo = wr_ok && !reg_addr[0];
  assign wr_hi = wr_ok &&  reg_addr[0];

  assign off_nxt = {1'b0, off_q} + (OFF_W+1)'(1);
  assign lim     = ((OFF_W+1)'(size_q) + (OFF_W+1)'(1)) << CPP_LOG2;
  assign wrap    = (off_nxt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      inner_q <= '0;
      outer_q <= '0;
      base_q  <= '0;
      share_q <= '0;
      size_q  <= '0;
    end else begin
      if (wr_lo) begin
        base_q[31:16] <= reg_wdata[31:16];
        share_q       <= (reg_wdata[11:10] == 2'b11) ? 2'b00 : reg_wdata[11:10];
        size_q        <= reg_wdata[7:0];
      end
      if (wr_hi) begin
        valid_q       <= reg_wdata[31];
        inner_q       <= reg_wdata[29:27];
        outer_q       <= reg_wdata[23:21];
        base_q[51:32] <= reg_wdata[19:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     off_q <= '0;
    else if (wr_ok)                 off_q <= '0;
    else if (fetch_adv && valid_q)  off_q <= wrap ? '0 : off_nxt[OFF_W-1:0];
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {base_q[31:16], 4'b0, share_q, 2'b0, size_q};
      2'd1:    reg_rdata = {valid_q, 1'b0, inner_q, 3'b0, outer_q, 1'b0, base_q[51:32]};
      2'd2:    reg_rdata = 32'({off_q, {CMD_LOG2{1'b0}}});
      default: reg_rdata = '0;
    endcase
  end

  assign fetch_addr = FETCH_AW'({base_q, 16'b0}) + FETCH_AW'({off_q, {CMD_LOG2{1'b0}}});
  assign q_valid = valid_q;
  assign q_pages = size_q;
  assign q_inner = inner_q;
  assign q_outer = outer_q;
  assign q_share = share_q;

  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (eng_enable || !eng_quiescent)) |=>
      ($stable(valid_q) && $stable(base_q) && $stable(size_q) && $stable(share_q)
       && $stable(inner_q) && $stable(outer_q)));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (fetch_addr == FETCH_AW'({base_q, 16'b0})));

  // R9
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, off_q} < lim));

  // R5
  share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_share != 2'b11));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_valid && !wr_ok) |=> $stable(off_q));

  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && q_valid && !wr_ok && !wrap) |=>
      (off_q == $past(off_q) + OFF_W'(1)));
endmodule

// File: tb/test_cmdq_desc_reg.sv
`timescale 1ns/1ps
module test_cmdq_desc_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_enable = 1'b0;
  logic        eng_quiescent = 1'b1;
  logic        fetch_adv = 1'b0;
  logic [47:0] fetch_addr;
  logic        q_valid;
  logic [7:0]  q_pages;
  logic [2:0]  q_inner, q_outer;
  logic [1:0]  q_share;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmdq_desc_reg i_cmdq_desc_reg (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_enable(eng_enable),
    .eng_quiescent(eng_quiescent), .fetch_adv(fetch_adv), .fetch_addr(fetch_addr),
    .q_valid(q_valid), .q_pages(q_pages), .q_inner(q_inner), .q_outer(q_outer),
    .q_share(q_share)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic adv(input int n);
    @(negedge clk);
    fetch_adv = 1'b1;
    repeat (n) @(negedge clk);
    fetch_adv = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R2 word0", d, 0);
    rd(2'd1, d); chk("R2 word1", d, 0);
    rd(2'd2, d); chk("R2 word2", d, 0);
    chk("R2 valid", q_valid, 0);
    chk("R2 fetch_addr", fetch_addr, 0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R3 word1 reserved", d, 32'hB8EF_FFFF);
    rd(2'd0, d); chk("R4 word0 bits15:12", d, 32'hFFFF_00FF);
    chk("R5 share out", q_share, 2'b00);
    chk("R1 pages", q_pages, 8'hFF);
    chk("R1 inner", q_inner, 3'd7);
    chk("R1 outer", q_outer, 3'd7);
    chk("R10 fetch 48-bit", fetch_addr, 48'hFFFF_FFFF_0000);
    wr(2'd0, 32'h1234_5678);
    rd(2'd0, d); chk("R1 word0", d, 32'h1234_0478);
    rd(2'd1, d); chk("R1 word1 kept", d, 32'hB8EF_FFFF);
    chk("R5 share 01", q_share, 2'b01);
    wr(2'd0, 32'h0000_0800);
    chk("R5 share 10", q_share, 2'b10);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R11 word2 read-only", d, 0);
    rd(2'd3, d); chk("R11 word3", d, 0);
  endtask

  task automatic t_wrap0;
    logic [31:0] d;
    wr(2'd1, 32'h8000_0000);
    wr(2'd0, 32'h0001_0000);
    chk("R10 base only", fetch_addr, 48'h0_0001_0000);
    adv(127);
    rd(2'd2, d); chk("R11 offset", d, 32'h0000_0FE0);
    chk("R10 last cmd", fetch_addr, 48'h0_0001_0FE0);
    adv(1);
    rd(2'd2, d); chk("R9 wrap size0", d, 0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    adv(5);
    rd(2'd2, d); chk("R8 step 32", d, 32'hA0);
    wr(2'd0, 32'h0001_0000);
    rd(2'd2, d); chk("R6 clear lo", d, 0);
    adv(3);
    wr(2'd1, 32'h8000_0000);
    rd(2'd2, d); chk("R6 clear hi", d, 0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    adv(2);
    eng_enable = 1'b1;
    wr(2'd0, 32'hFFFF_0000);
    rd(2'd0, d); chk("R7 enabled lo", d, 32'h0001_0000);
    rd(2'd2, d); chk("R7 offset kept", d, 32'h40);
    eng_enable = 1'b0; eng_quiescent = 1'b0;
    wr(2'd1, 32'h0);
    chk("R7 busy hi", q_valid, 1'b1);
    eng_quiescent = 1'b1;
  endtask

  task automatic t_invalid;
    logic [31:0] d;
    wr(2'd1, 32'h0);
    adv(4);
    rd(2'd2, d); chk("R8 no advance invalid", d, 0);
    chk("R8 valid low", q_valid, 1'b0);
  endtask

  task automatic t_wrap255;
    logic [31:0] d;
    wr(2'd1, 32'h8000_0001);
    wr(2'd0, 32'h0000_00FF);
    chk("R10 base bit32", fetch_addr, 48'h1_0000_0000);
    adv(32767);
    rd(2'd2, d); chk("R9 last size255", d, 32'h000F_FFE0);
    chk("R10 last addr", fetch_addr, 48'h1_000F_FFE0);
    adv(1);
    rd(2'd2, d); chk("R9 wrap size255", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fields;
    t_wrap0;
    t_clear;
    t_lock;
    t_invalid;
    t_wrap255;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule